// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the transfer-complete pulses of a bank of DMA channels and merges them into a single level-sensitive interrupt for the processor. A channel raises its completion pulse when its transfer count reaches zero. Each channel also supplies a 32-bit options word. In that word, bit 20 allows the channel to raise an interrupt, and bits 19..16 carry a 4-bit completion code. The code selects the pending bit that the channel sets. Because the code is programmable, any channel can set any pending bit, and several channels can share one bit.

Software reaches two 16-bit registers over a small register bus. The pending register records completions and is cleared by writing ones to it. The enable register masks pending bits before they reach the interrupt line. A two-state machine registers the interrupt output. It enters `IRQ_RAISED` through transition T_ASSERT when some bit is both pending and enabled. It returns to `IRQ_QUIET` through transition T_RELEASE when no such bit remains. In every other cycle it stays in its current state (T_HOLD).

Top module: `dma_done_irq_agg`

## Requirements
- R1: A completion pulse from a channel whose options bit 20 is 1 sets pending bit number options[19:16]. The bit is visible on the first clock edge after the pulse.
- R2: A completion pulse from a channel whose options bit 20 is 0 changes no pending bit.
- R3: When several channels complete in the same cycle, every pending bit they target is set on that edge. Channels that share a code set that one bit, and a channel may set a bit whose index differs from its own.
- R4: A write to address 0 clears each pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R5: If a completion sets a pending bit in the same cycle that a write to address 0 clears it, the bit ends up set.
- R6: A write to address 1 loads the enable register with the write data. It leaves the pending register unchanged.
- R7: The interrupt output equals, one clock later, the OR over all bits of (pending AND enable). For example, when bit 8 is pending and enabled and every other pending bit is disabled, the output goes high.
- R8: After reset, the pending register, the enable register and the interrupt output are all 0.
- R9: The read data shows the pending register when the address is 0 and the enable register when the address is 1, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_done | input | 16 | One completion pulse per channel |
| chan_opt | input | 512 | Options words, channel n in bits [32n+31:32n] |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 pending, 1 enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The assertions check four rules on every cycle:
- the interrupt output tracks the masked pending OR with a one-cycle lag;
- every decoded set reaches the pending register, including when a clear write hits the same bit;
- a pending bit falls only after a clear write;
- an enable write lands unchanged.

Other behaviour shows up only in the bench's scenarios:
- the code-to-bit mapping for every channel and code pair, with the interrupt-enable bit clear and set;
- the merging of simultaneous and shared completions;
- the reset state and the exact edge on which the interrupt output responds to a masking change.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int OPT_W        = 32;
    localparam int OPT_IEN_BIT  = 20;
    localparam int OPT_CODE_LSB = 16;
    localparam int CODE_W       = 4;
    localparam int REG_ADDR_W   = 1;

    localparam logic [REG_ADDR_W-1:0] ADDR_PEND = 1'b0;
    localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 1'b1;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irqagg_code_decode.sv
module irqagg_code_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int NUM_BITS = 16
) (
    input  logic [NUM_CH-1:0]       done_i,
    input  logic [NUM_CH*OPT_W-1:0] opt_i,
    output logic [NUM_BITS-1:0]     set_o
);
    logic [NUM_BITS-1:0] hit [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [OPT_W-1:0]  word;
        logic              ien;
        logic [CODE_W-1:0] code;
        logic              unused_fields;

        assign word = opt_i[ch*OPT_W +: OPT_W];
        assign ien  = word[OPT_IEN_BIT];
        assign code = word[OPT_CODE_LSB +: CODE_W];
        // Codes beyond NUM_BITS shift out and select nothing.
        assign hit[ch] = (done_i[ch] && ien) ? (NUM_BITS'(1) << code) : '0;
        assign unused_fields = ^{word[OPT_W-1:OPT_IEN_BIT+1], word[OPT_CODE_LSB-1:0]};
    end

    always_comb begin
        set_o = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            set_o = set_o | hit[ch];
        end
    end
endmodule

// File: rtl/irqagg_pend_bank.sv
module irqagg_pend_bank #(
    parameter int NUM_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] set_i,
    input  logic [NUM_BITS-1:0] clr_i,
    output logic [NUM_BITS-1:0] pend_o
);
    for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[b] <= 1'b0;
            end else if (set_i[b]) begin
                pend_o[b] <= 1'b1;      // a set outranks a clear
            end else if (clr_i[b]) begin
                pend_o[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irqagg_mask_reg.sv
module irqagg_mask_reg #(
    parameter int NUM_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [NUM_BITS-1:0] data_i,
    output logic [NUM_BITS-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (wr_i) begin
            mask_o <= data_i;
        end
    end
endmodule

// File: rtl/irqagg_irq_fsm.sv
module irqagg_irq_fsm
    import irqagg_pkg::*;
#(
    parameter int NUM_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] pend_i,
    input  logic [NUM_BITS-1:0] mask_i,
    output logic                irq_o
);
    irq_state_e state_q, state_d;
    logic       any_live;

    assign any_live = |(pend_i & mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_live)  state_d = IRQ_RAISED;  // T_ASSERT
            IRQ_RAISED: if (!any_live) state_d = IRQ_QUIET;   // T_RELEASE
            default:                   state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/dma_done_irq_agg.sv
module dma_done_irq_agg
    import irqagg_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int NUM_BITS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         chan_done,
    input  logic [NUM_CH*OPT_W-1:0]   chan_opt,
    input  logic                      bus_we,
    input  logic [REG_ADDR_W-1:0]     bus_addr,
    input  logic [NUM_BITS-1:0]       bus_wdata,
    output logic [NUM_BITS-1:0]       bus_rdata,
    output logic                      irq_out
);
    logic [NUM_BITS-1:0] set_vec;
    logic [NUM_BITS-1:0] clr_vec;
    logic [NUM_BITS-1:0] pend_q;
    logic [NUM_BITS-1:0] en_q;
    logic                wr_pend;
    logic                wr_mask;

    assign wr_pend = bus_we && (bus_addr == ADDR_PEND);
    assign wr_mask = bus_we && (bus_addr == ADDR_MASK);
    assign clr_vec = wr_pend ? bus_wdata : '0;

    irqagg_code_decode #(.NUM_CH(NUM_CH), .NUM_BITS(NUM_BITS)) u_decode (
        .done_i (chan_done),
        .opt_i  (chan_opt),
        .set_o  (set_vec)
    );

    irqagg_pend_bank #(.NUM_BITS(NUM_BITS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend_q)
    );

    irqagg_mask_reg #(.NUM_BITS(NUM_BITS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_mask),
        .data_i (bus_wdata),
        .mask_o (en_q)
    );

    irqagg_irq_fsm #(.NUM_BITS(NUM_BITS)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .mask_i (en_q),
        .irq_o  (irq_out)
    );

    always_comb begin
        bus_rdata = (bus_addr == ADDR_MASK) ? en_q : pend_q;
    end
endmodule

// File: rtl/dma_done_irq_agg_checker.sv
module dma_done_irq_agg_checker
    import irqagg_pkg::*;
#(
    parameter int NUM_BITS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [NUM_BITS-1:0]   bus_wdata,
    input logic [NUM_BITS-1:0]   set_vec,
    input logic [NUM_BITS-1:0]   pend_q,
    input logic [NUM_BITS-1:0]   en_q,
    input logic                  irq_out
);
    assert_irq_lags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(pend_q & en_q))));

    assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_PEND && (set_vec & bus_wdata) != '0)
        |=> ((pend_q & $past(set_vec & bus_wdata)) == $past(set_vec & bus_wdata)));

    assert_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q) != '0) |-> $past(bus_we && bus_addr == ADDR_PEND));

    assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_MASK) |=> (en_q == $past(bus_wdata)));
endmodule

bind dma_done_irq_agg dma_done_irq_agg_checker #(.NUM_BITS(NUM_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .set_vec   (set_vec),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .irq_out   (irq_out)
);

// File: tb/dma_done_irq_agg_bench.sv
`timescale 1ns/1ps
module dma_done_irq_agg_bench;
    localparam int NC = 16;
    localparam int NB = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NC-1:0]  chan_done = '0;
    logic [NC*32-1:0] chan_opt;
    logic           bus_we = 1'b0;
    logic           bus_addr = 1'b0;
    logic [NB-1:0]  bus_wdata = '0;
    logic [NB-1:0]  bus_rdata;
    logic           irq_out;

    logic [31:0] opt [NC];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) chan_opt[i*32 +: 32] = opt[i];
    end

    dma_done_irq_agg u_dma_done_irq_agg (
        .clk(clk), .rst_n(rst_n), .chan_done(chan_done), .chan_opt(chan_opt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_opt(bit ien, int code);
        return {11'd0, ien, 4'(code), 16'd0};
    endfunction

    task automatic wr(bit a, logic [NB-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(bit a, output logic [NB-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(logic [NC-1:0] m);
        chan_done = m;
        @(negedge clk);
        chan_done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] r;
        logic [NB-1:0] exp;
        for (int i = 0; i < NC; i++) opt[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state, R9 address decode
        rd(0, r); chk("R8 pending", 32'(r), 0);
        rd(1, r); chk("R8 enable", 32'(r), 0);
        chk("R8 irq", 32'(irq_out), 0);

        // R1 full channel x code sweep, R4 clear back to zero
        for (int ch = 0; ch < NC; ch++) begin
            for (int c = 0; c < NB; c++) begin
                opt[ch] = mk_opt(1, c);
                pulse(NC'(1) << ch);
                rd(0, r); chk("R1 code select", 32'(r), 32'(1) << c);
                wr(0, '1);
                rd(0, r); chk("R4 clear all", 32'(r), 0);
            end
            opt[ch] = '0;
        end

        // R2 interrupt-enable bit clear: nothing set
        for (int ch = 0; ch < NC; ch++) begin
            opt[ch] = mk_opt(0, ch);
            pulse(NC'(1) << ch);
            rd(0, r); chk("R2 disabled channel", 32'(r), 0);
        end

        // R3 simultaneous completions with a mix of codes and enables
        for (int i = 0; i < NC; i++) opt[i] = mk_opt((i % 3) != 0, (i * 5 + 3) % 16);
        for (int p = 0; p < 4; p++) begin
            logic [NC-1:0] m;
            m = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h00F0 : (p == 2) ? 16'hA5A5 : 16'h8001;
            exp = '0;
            for (int i = 0; i < NC; i++)
                if (m[i] && (i % 3) != 0) exp[(i * 5 + 3) % 16] = 1'b1;
            pulse(m);
            rd(0, r); chk("R3 multi-channel", 32'(r), 32'(exp));
            wr(0, '1);
        end
        // R3 all channels share code 7
        for (int i = 0; i < NC; i++) opt[i] = mk_opt(1, 7);
        pulse('1);
        rd(0, r); chk("R3 shared code", 32'(r), 32'h0080);
        wr(0, '1);

        // R4 write zero keeps bits, write ones clears only those
        for (int i = 0; i < NC; i++) opt[i] = mk_opt(1, i);
        pulse('1);
        rd(0, r); chk("R3 identity fill", 32'(r), 32'hFFFF);
        wr(0, 16'h0000);
        rd(0, r); chk("R4 write zero", 32'(r), 32'hFFFF);
        wr(0, 16'h00FF);
        rd(0, r); chk("R4 partial clear", 32'(r), 32'hFF00);
        wr(0, '1);

        // R5 set and clear on one bit in the same cycle
        pulse(16'h0018);                 // bits 3 and 4 pending
        chan_done = 16'h0008;            // channel 3 sets bit 3 again
        bus_we = 1'b1; bus_addr = 0; bus_wdata = 16'h0018;
        @(negedge clk);
        chan_done = '0; bus_we = 1'b0; bus_wdata = '0;
        rd(0, r); chk("R5 set wins", 32'(r), 32'h0008);
        wr(0, '1);

        // R6 enable write and readback, pending untouched
        pulse(16'h0021);
        for (int p = 0; p < 4; p++) begin
            logic [NB-1:0] d;
            d = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'h5A3C : 16'h8001;
            wr(1, d);
            rd(1, r); chk("R6 enable readback", 32'(r), 32'(d));
            rd(0, r); chk("R6 pending intact", 32'(r), 32'h0021);
        end
        wr(0, '1);
        wr(1, '0);
        @(negedge clk);

        // R7 masking and one-cycle lag for every bit
        for (int b = 0; b < NB; b++) begin
            wr(1, ~(NB'(1) << b));
            pulse(NC'(1) << b);          // bit b pending, masked
            chk("R7 masked low", 32'(irq_out), 0);
            @(negedge clk);
            chk("R7 masked stays low", 32'(irq_out), 0);
            wr(1, NB'(1) << b);
            chk("R7 lag on enable", 32'(irq_out), 0);
            @(negedge clk);
            chk("R7 raised", 32'(irq_out), 1);
            wr(0, NB'(1) << b);
            chk("R7 lag on clear", 32'(irq_out), 1);
            @(negedge clk);
            chk("R7 released", 32'(irq_out), 0);
        end

        // R7 bit 8 pending and enabled alone, others disabled but pending
        wr(1, 16'h0100);
        pulse(16'hFFFF);
        @(negedge clk);
        chk("R7 bit 8 example", 32'(irq_out), 1);
        wr(0, 16'h0100);
        @(negedge clk);
        chk("R7 only disabled pending", 32'(irq_out), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule